// File: doc/BRIEF.md
# Control Register Port Responder

This block sits on the PHY side of a 16-bit parallel control-register port and answers a master that moves through a sequence of strobes. There are four strobes: capture-address, capture-data, commit and fetch. A single 16-bit input bus carries either an offset or a write value, depending on which strobe is active. The responder stores the offset in one capture phase and the write value in a separate capture phase. The value reaches a register only on a later commit strobe. A fetch strobe presents the addressed register on the 16-bit output bus.

Every strobe gets a four-phase acknowledge. The acknowledge rises a parameterised number of cycles after the strobe, so a master's polling loop can be exercised with real waiting. The acknowledge then stays high until the strobe is released. The register bank is a plain storage model decoded sparsely across two windows. Offsets outside those windows read as zero and discard writes.

The handshake is run by one four-state machine:
- `HS_IDLE`: no transaction is open.
- `HS_WAIT`: the latency counter is running.
- `HS_ACK`: the acknowledge is high.
- `HS_FAULT`: a strobe collision was seen.

The transitions are:
- *open*: IDLE to WAIT, when exactly one strobe is high and the latency is nonzero.
- *fire*: IDLE or WAIT to ACK, when the latency expires. The strobe's action is performed on this edge.
- *abort*: WAIT to IDLE, when the strobe drops early.
- *release*: ACK to IDLE, when the strobe falls.
- *collide*: IDLE, WAIT or ACK to FAULT, when the strobe set changes to anything other than the held strobe or all-low.
- *clear*: FAULT to IDLE, when every strobe is low.

Top module: `crport_target`

## Requirements
- R1: The offset is taken from `din_i` on the fire edge of a capture-address transaction.
- R2: A capture-data transaction stores `din_i` as the pending value and changes no register.
- R3: A commit transaction copies the pending value into the register at the current offset.
- R4: A fetch transaction drives the addressed register on `dout_o` while `ack_o` is high. `dout_o` is 0x0000 whenever `ack_o` is low.
- R5: With a strobe applied before clock edge k, `ack_o` first goes high after edge k+LATENCY. A strobe dropped before that point leaves the state machine without acknowledge and without effect.
- R6: `ack_o` stays high while the strobe stays high, and goes low after the first edge at which the strobe is seen low.
- R7: Only offsets 0x0000–0x0007 and 0x2010–0x201F hold storage. Fetches elsewhere return 0x0000, and commits elsewhere change no register.
- R8: More than one strobe high, or a strobe set other than the held strobe during a transaction, withholds `ack_o` and raises `proto_err_o`. The flag holds until every strobe is low.
- R9: The current offset and the pending value persist across transactions until they are captured again.
- R10: After reset, `ack_o`, `dout_o` and `proto_err_o` are zero. The current offset, the pending value and all registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_addr_i | input | 1 | Capture-address strobe |
| cap_data_i | input | 1 | Capture-data strobe |
| commit_i | input | 1 | Commit strobe |
| fetch_i | input | 1 | Fetch strobe |
| din_i | input | 16 | Offset or write value |
| dout_o | output | 16 | Fetched register value |
| ack_o | output | 1 | Four-phase acknowledge |
| proto_err_o | output | 1 | Strobe collision flag |

## Verification
The hardest cases to reach from the ports need strobe timing that a well-behaved master never produces:
- a strobe withdrawn while the latency counter is still running;
- a second strobe raised during the wait;
- a strobe held high long after the acknowledge.

The stimulus therefore drives strobes directly, edge by edge. It aborts a capture-address before it fires and then fetches, to show the offset did not move. It overlaps two strobes and releases them one at a time. A behavioural per-cycle model follows every edge, so any early or late acknowledge is caught on the cycle it happens.

// File: rtl/crport_pkg.sv
package crport_pkg;
    // Strobe vector bit positions; the FSM holds a one-hot copy of these
    localparam int SB_ADDR   = 0;
    localparam int SB_DATA   = 1;
    localparam int SB_COMMIT = 2;
    localparam int SB_FETCH  = 3;
    localparam int NSB       = 4;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_WAIT  = 2'd1,
        HS_ACK   = 2'd2,
        HS_FAULT = 2'd3
    } hs_state_e;
endpackage

// File: rtl/crport_strobe_dec.sv
module crport_strobe_dec
    import crport_pkg::*;
(
    input  logic [NSB-1:0] strb,
    output logic           none,
    output logic           single,
    output logic           multi
);
    logic [$clog2(NSB+1)-1:0] nhigh;

    always_comb begin
        nhigh = '0;
        for (int i = 0; i < NSB; i++)
            nhigh = nhigh + {{($clog2(NSB+1)-1){1'b0}}, strb[i]};
    end

    assign none   = (nhigh == '0);
    assign single = (nhigh == 1);
    assign multi  = !none && !single;
endmodule

// File: rtl/crport_hs_fsm.sv
module crport_hs_fsm
    import crport_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NSB-1:0] strb,
    input  logic           none,
    input  logic           single,
    input  logic           multi,
    output logic           ack,
    output logic           fault,
    output logic           ack_nxt,
    output logic           fire,
    output logic [NSB-1:0] fire_sel
);
    localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'((LATENCY > 0) ? LATENCY - 1 : 0);

    hs_state_e      state_q, state_d;
    logic [NSB-1:0] held_q, held_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            held_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        held_d   = held_q;
        cnt_d    = cnt_q;
        fire     = 1'b0;
        fire_sel = held_q;
        unique case (state_q)
            HS_IDLE: begin
                if (multi) begin
                    state_d = HS_FAULT;
                end else if (single) begin
                    held_d   = strb;
                    fire_sel = strb;
                    if (LATENCY == 0) begin
                        state_d = HS_ACK;
                        fire    = 1'b1;
                    end else begin
                        state_d = HS_WAIT;
                        cnt_d   = CNT_LOAD;
                    end
                end
            end
            HS_WAIT: begin
                if (strb == held_q) begin
                    if (cnt_q == '0) begin
                        state_d = HS_ACK;
                        fire    = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end else if (none) begin
                    state_d = HS_IDLE;
                end else begin
                    state_d = HS_FAULT;
                end
            end
            HS_ACK: begin
                if (strb != held_q)
                    state_d = none ? HS_IDLE : HS_FAULT;
            end
            HS_FAULT: begin
                if (none)
                    state_d = HS_IDLE;
            end
            default: state_d = HS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ack     = (state_q == HS_ACK);
        fault   = (state_q == HS_FAULT);
        ack_nxt = (state_d == HS_ACK);
    end

    a_r8_collision_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        multi |=> !ack);
    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault && !none |=> fault);
    a_r6_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ack && single && $stable(strb) |=> ack);
    a_r6_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        ack && none |=> !ack);
    a_r5_ack_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(single));
endmodule

// File: rtl/crport_regbank.sv
module crport_regbank #(
    parameter int          DW      = 16,
    parameter int          AW      = 16,
    parameter logic [15:0] LO_BASE = 16'h0000,
    parameter int          LO_NUM  = 8,
    parameter logic [15:0] HI_BASE = 16'h2010,
    parameter int          HI_NUM  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int NREG = LO_NUM + HI_NUM;

    logic [NREG-1:0][DW-1:0] store;
    logic [NREG-1:0]         hit_w, hit_r;

    // Sparse decode: two windows of contiguous offsets
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        localparam logic [AW-1:0] OFF = (g < LO_NUM) ? AW'(LO_BASE + g)
                                                     : AW'(HI_BASE + (g - LO_NUM));
        assign hit_w[g] = (wr_addr == OFF);
        assign hit_r[g] = (rd_addr == OFF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NREG; i++)
                if (hit_w[i]) store[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (hit_r[i]) rd_data = store[i];
    end

    a_r7_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (hit_w == '0) |=> $stable(store));
endmodule

// File: rtl/crport_target.sv
module crport_target
    import crport_pkg::*;
#(
    parameter int          DW      = 16,
    parameter int          AW      = 16,
    parameter int          LATENCY = 2,
    parameter logic [15:0] LO_BASE = 16'h0000,
    parameter int          LO_NUM  = 8,
    parameter logic [15:0] HI_BASE = 16'h2010,
    parameter int          HI_NUM  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_addr_i,
    input  logic          cap_data_i,
    input  logic          commit_i,
    input  logic          fetch_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] dout_o,
    output logic          ack_o,
    output logic          proto_err_o
);
    logic [NSB-1:0] strb;
    logic           s_none, s_single, s_multi;
    logic           ack_nxt, fire;
    logic [NSB-1:0] fire_sel;
    logic [AW-1:0]  cur_addr;
    logic [DW-1:0]  pend_data, dout_q, rd_data;
    logic           bank_we;

    always_comb begin
        strb            = '0;
        strb[SB_ADDR]   = cap_addr_i;
        strb[SB_DATA]   = cap_data_i;
        strb[SB_COMMIT] = commit_i;
        strb[SB_FETCH]  = fetch_i;
    end

    crport_strobe_dec u_dec (
        .strb   (strb),
        .none   (s_none),
        .single (s_single),
        .multi  (s_multi)
    );

    crport_hs_fsm #(.LATENCY(LATENCY)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb     (strb),
        .none     (s_none),
        .single   (s_single),
        .multi    (s_multi),
        .ack      (ack_o),
        .fault    (proto_err_o),
        .ack_nxt  (ack_nxt),
        .fire     (fire),
        .fire_sel (fire_sel)
    );

    assign bank_we = fire && fire_sel[SB_COMMIT];

    crport_regbank #(
        .DW(DW), .AW(AW), .LO_BASE(LO_BASE), .LO_NUM(LO_NUM),
        .HI_BASE(HI_BASE), .HI_NUM(HI_NUM)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_we),
        .wr_addr (cur_addr),
        .wr_data (pend_data),
        .rd_addr (cur_addr),
        .rd_data (rd_data)
    );

    // Offset and pending value: captured on fire, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            pend_data <= '0;
        end else if (fire) begin
            if (fire_sel[SB_ADDR]) cur_addr  <= AW'(din_i);
            if (fire_sel[SB_DATA]) pend_data <= din_i;
        end
    end

    // Read data: loaded on a fetch fire, kept through ack, cleared after
    always_ff @(posedge clk) begin
        if (!rst_n)                        dout_q <= '0;
        else if (fire && fire_sel[SB_FETCH]) dout_q <= rd_data;
        else if (!ack_nxt)                 dout_q <= '0;
    end

    assign dout_o = dout_q;

    a_r4_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> dout_o == '0);
    a_r1_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
        fire && fire_sel[SB_ADDR] |=> cur_addr == AW'($past(din_i)));
    a_r9_addr_persists: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && fire_sel[SB_ADDR]) |=> $stable(cur_addr));
    a_r2_data_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        fire && fire_sel[SB_DATA] |-> !bank_we);
endmodule

// File: tb/crport_target_tb.sv
`timescale 1ns/1ps
module crport_target_tb;
    localparam int LAT = 2;
    localparam int S_ADDR = 0, S_DATA = 1, S_COMMIT = 2, S_FETCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        caddr = 1'b0, cdata = 1'b0, commit = 1'b0, fetch = 1'b0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        ack, perr;

    int n_cmp = 0;
    int n_bad = 0;
    int wd    = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    crport_target #(.LATENCY(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cap_addr_i(caddr), .cap_data_i(cdata), .commit_i(commit), .fetch_i(fetch),
        .din_i(din), .dout_o(dout), .ack_o(ack), .proto_err_o(perr)
    );

    // ---------------- behavioural reference model ----------------
    int          m_ph;      // 0 idle, 1 waiting, 2 acknowledged, 3 fault
    int          m_left;
    logic [3:0]  m_held;
    logic [15:0] m_addr, m_pend, m_dout;
    int          mem [int];

    function automatic bit mapped(input int a);
        return (a < 8) || (a >= 'h2010 && a <= 'h201F);
    endfunction

    task automatic m_act(input logic [3:0] k);
        if (k[S_ADDR]) m_addr = din;
        if (k[S_DATA]) m_pend = din;
        if (k[S_COMMIT] && mapped(int'(m_addr))) mem[int'(m_addr)] = int'(m_pend);
        if (k[S_FETCH])
            m_dout = (mapped(int'(m_addr)) && mem.exists(int'(m_addr))) ? 16'(mem[int'(m_addr)]) : 16'h0;
    endtask

    always @(posedge clk) begin
        logic [3:0] s;
        s = {fetch, commit, cdata, caddr};
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_held = '0;
            m_addr = '0; m_pend = '0; m_dout = '0;
            mem.delete();
        end else begin
            case (m_ph)
                0: if ($countones(s) > 1) m_ph = 3;
                   else if (s != 0) begin
                       m_held = s;
                       if (LAT == 0) begin m_act(s); m_ph = 2; end
                       else begin m_left = LAT; m_ph = 1; end
                   end
                1: if (s == m_held) begin
                       m_left--;
                       if (m_left == 0) begin m_act(s); m_ph = 2; end
                   end else m_ph = (s == 0) ? 0 : 3;
                2: if (s != m_held) begin
                       m_dout = '0;
                       m_ph = (s == 0) ? 0 : 3;
                   end
                default: if (s == 0) m_ph = 0;
            endcase
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp += 3;
            if (ack !== (m_ph == 2)) begin
                n_bad++; $display("FAIL R5/R6 ack: actual %0b expected %0b at %0t", ack, m_ph == 2, $time);
            end
            if (perr !== (m_ph == 3)) begin
                n_bad++; $display("FAIL R8 proto_err: actual %0b expected %0b at %0t", perr, m_ph == 3, $time);
            end
            if (dout !== m_dout) begin
                n_bad++; $display("FAIL R4 dout: actual %h expected %h at %0t", dout, m_dout, $time);
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input int sel, input logic v);
        case (sel)
            S_ADDR:   caddr  = v;
            S_DATA:   cdata  = v;
            S_COMMIT: commit = v;
            default:  fetch  = v;
        endcase
    endtask

    task automatic xact(input int sel, input logic [15:0] v, input int hold, output logic [15:0] rv);
        int cyc = 0;
        @(negedge clk);
        din = v;
        drive(sel, 1'b1);
        do begin @(negedge clk); cyc++; end while (!ack && cyc < 40);
        chk("R5 ack latency", cyc, LAT + 1);
        rv = dout;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R6 ack held", int'(ack), 1);
        end
        drive(sel, 1'b0);
        @(negedge clk);
        chk("R6 ack released", int'(ack), 0);
        chk("R4 dout idle", int'(dout), 0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
            finish_run();
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ack reset", int'(ack), 0);
        chk("R10 dout reset", int'(dout), 0);
        chk("R10 err reset", int'(perr), 0);

        // R10: offset and bank start at zero
        xact(S_FETCH, 16'h0, 0, r);           chk("R10 reg0 reset", int'(r), 0);
        xact(S_DATA, 16'h1234, 0, r);
        xact(S_COMMIT, 16'h0, 0, r);
        xact(S_FETCH, 16'h0, 0, r);           chk("R10 default offset 0", int'(r), 'h1234);

        // R1, R3: high window
        xact(S_ADDR, 16'h2015, 0, r);
        xact(S_DATA, 16'hBEEF, 0, r);
        xact(S_COMMIT, 16'h0, 0, r);
        xact(S_FETCH, 16'h0, 0, r);           chk("R3 commit 0x2015", int'(r), 'hBEEF);

        // R2: capture-data alone changes nothing
        xact(S_ADDR, 16'h0003, 0, r);
        xact(S_DATA, 16'h5555, 0, r);
        xact(S_COMMIT, 16'h0, 0, r);
        xact(S_DATA, 16'hAAAA, 0, r);
        xact(S_FETCH, 16'h0, 0, r);           chk("R2 no write on capture", int'(r), 'h5555);

        // R9: offset and pending value persist; R6 long hold
        xact(S_FETCH, 16'h0, 5, r);           chk("R9 offset persists", int'(r), 'h5555);
        xact(S_COMMIT, 16'h0, 0, r);
        xact(S_FETCH, 16'h0, 0, r);           chk("R9 pending persists", int'(r), 'hAAAA);

        // R7: unmapped offsets
        xact(S_ADDR, 16'h0100, 0, r);
        xact(S_DATA, 16'h7777, 0, r);
        xact(S_COMMIT, 16'h0, 0, r);
        xact(S_FETCH, 16'h0, 0, r);           chk("R7 unmapped 0x0100", int'(r), 0);
        xact(S_ADDR, 16'h2020, 0, r);
        xact(S_COMMIT, 16'h0, 0, r);
        xact(S_FETCH, 16'h0, 0, r);           chk("R7 unmapped 0x2020", int'(r), 0);
        xact(S_ADDR, 16'h201F, 0, r);
        xact(S_COMMIT, 16'h0, 0, r);
        xact(S_FETCH, 16'h0, 0, r);           chk("R7 top offset 0x201F", int'(r), 'h7777);
        xact(S_ADDR, 16'h2015, 0, r);
        xact(S_FETCH, 16'h0, 0, r);           chk("R7 no alias into 0x2015", int'(r), 'hBEEF);

        // R5: aborted capture-address has no effect
        @(negedge clk); din = 16'h0003; caddr = 1'b1;
        @(negedge clk); caddr = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        chk("R5 abort no ack", int'(ack), 0);
        xact(S_FETCH, 16'h0, 0, r);           chk("R5 abort offset unchanged", int'(r), 'hBEEF);

        // R8: collision
        @(negedge clk); din = 16'h0001; caddr = 1'b1; fetch = 1'b1;
        repeat (LAT + 3) @(negedge clk);
        chk("R8 no ack on collision", int'(ack), 0);
        chk("R8 error raised", int'(perr), 1);
        fetch = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 error held with one strobe", int'(perr), 1);
        caddr = 1'b0;
        @(negedge clk);
        chk("R8 error cleared", int'(perr), 0);
        xact(S_FETCH, 16'h0, 0, r);           chk("R8 collision had no effect", int'(r), 'hBEEF);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule